// File: doc/BRIEF.md
# Upper Memory Bank-Switch Controller

This block controls the banked memory window that occupies $D000–$FFFF in an 8-bit system. The system has two 64 KB RAMs, one main and one auxiliary, and a 12 KB ROM. The block holds a small mode register. Software changes that register by touching any address in the sixteen-byte window $C080–$C08F. The access may be a read or a write.

For every bus access the block works out the following:
- whether a read inside the banked window is served by ROM or by RAM;
- whether a write there may reach RAM;
- which of the two RAMs is used;
- the physical RAM address.

The $D000–$DFFF page has two RAM banks. One of them is relocated to physical $C000–$CFFF. The block also answers two status reads and the read of the switch window itself. The RAM and ROM arrays sit outside the block. The selects are plain combinational control outputs. The block applies no back-pressure: every presented access completes in its cycle.

Top module: `lcbank_ctrl`

## Requirements
- R1: A valid access, read or write, to any address in $C080–$C08F loads the 4-bit mode register with address bits [3:0] AND 4'b1011. The new mode governs accesses from the next cycle on. Other accesses leave the mode unchanged.
- R2: For an address at or above $D000, `rom_read` is 1 when mode bits [1:0] are 01 or 10. It is 0 when they are 00 or 11.
- R3: In mode 3'bxx1 (bit 0 set), a valid write at or above $D000 asserts `ram_we`. When mode bit 0 is clear, `ram_we` stays 0.
- R4: When mode bit 3 is set, addresses $D000–$DFFF map to `ram_addr` $C000–$CFFF, which is the address minus $1000. When bit 3 is clear, they map to themselves.
- R5: Addresses $E000–$FFFF always map to `ram_addr` equal to the address, whatever mode bit 3 holds.
- R6: Inside the window, `ram_aux` equals the `altzp` input.
- R7: Below $D000, `region_hit`, `rom_read`, `ram_we` and `ram_aux` are all 0, and `ram_addr` equals the address.
- R8: A valid read of $C011 asserts `stat_hit`. The returned data has bit 7 equal to the inverse of mode bit 3, and all other bits 0.
- R9: A valid read of $C012 asserts `stat_hit`. The returned data has bit 7 set when mode bits 0 and 1 are equal, and all other bits 0.
- R10: A valid read inside $C080–$C08F asserts `stat_hit` with data 0.
- R11: After reset the mode is 4'b0010, so the window reads ROM and blocks writes.
- R12: `ram_we` is 0 whenever `acc_valid` or `acc_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A bus access is presented this cycle |
| acc_we | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 16 | Bus address |
| altzp | input | 1 | Use auxiliary RAM for the banked window |
| region_hit | output | 1 | Address lies at or above $D000 |
| rom_read | output | 1 | A read here comes from ROM |
| ram_we | output | 1 | Write strobe allowed into RAM |
| ram_aux | output | 1 | RAM access goes to auxiliary RAM |
| ram_addr | output | 16 | Physical RAM address |
| stat_hit | output | 1 | Block drives read data for this access |
| stat_data | output | 8 | Read data for status and switch reads |

## Verification
The bench sweeps all sixteen switch addresses, once by read and once by write, and checks both `altzp` settings after each. It does this to catch decoders that ignore write-side switching, keep address bit 2, or invert the read-source encoding. Such a design would show ROM where RAM is expected, or would let writes through in the read-only modes. The bench probes $D123 and $E456 in both banks to catch a relocation applied to the wrong page. A design with that fault would move $E000–$FFFF, or leave bank 1 at $D000. Reads of $C011 and $C012 after each switch, together with a probe at $CFFF, expose status bits of the wrong polarity and window decodes that start one page early.

// File: rtl/lcbank_pkg.sv
package lcbank_pkg;
  localparam int unsigned MODE_W = 4;
  // Mode bit positions: these are decoded by the map and status logic
  localparam int unsigned MB_WR   = 0;
  localparam int unsigned MB_RSEL = 1;
  localparam int unsigned MB_BANK = 3;
  localparam logic [MODE_W-1:0] MODE_MASK  = 4'b1011;
  localparam logic [MODE_W-1:0] MODE_RESET = 4'b0010;

  function automatic logic mode_reads_rom(input logic [MODE_W-1:0] m);
    return m[MB_WR] ^ m[MB_RSEL];
  endfunction
endpackage

// File: rtl/lcbank_state.sv
module lcbank_state
  import lcbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SW_LOW_W = 4,
  parameter logic [ADDR_W-1:0] SW_BASE = 16'hC080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              sw_hit,
  output logic [MODE_W-1:0] mode_q
);
  assign sw_hit = acc_valid &&
                  (acc_addr[ADDR_W-1:SW_LOW_W] == SW_BASE[ADDR_W-1:SW_LOW_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= MODE_RESET;
    else if (sw_hit) mode_q <= acc_addr[MODE_W-1:0] & MODE_MASK;
  end
endmodule

// File: rtl/lcbank_map.sv
module lcbank_map
  import lcbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD000,
  parameter logic [ADDR_W-1:0] BANK_SIZE = 16'h1000
) (
  input  logic              acc_valid,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              altzp,
  input  logic [MODE_W-1:0] mode_q,
  output logic              region_hit,
  output logic              rom_read,
  output logic              ram_we,
  output logic              ram_aux,
  output logic [ADDR_W-1:0] ram_addr
);
  localparam logic [ADDR_W:0] BANK_END = {1'b0, WIN_BASE} + {1'b0, BANK_SIZE};

  logic in_bank_page;

  assign region_hit   = (acc_addr >= WIN_BASE);
  assign in_bank_page = region_hit && ({1'b0, acc_addr} < BANK_END);

  always_comb begin
    rom_read = region_hit && mode_reads_rom(mode_q);
    ram_we   = acc_valid && acc_we && region_hit && mode_q[MB_WR];
    ram_aux  = region_hit && altzp;
    ram_addr = (in_bank_page && mode_q[MB_BANK]) ? (acc_addr - BANK_SIZE) : acc_addr;
  end
endmodule

// File: rtl/lcbank_status.sv
module lcbank_status
  import lcbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] STAT_BANK = 16'hC011,
  parameter logic [ADDR_W-1:0] STAT_SRC  = 16'hC012
) (
  input  logic              acc_valid,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              sw_hit,
  input  logic [MODE_W-1:0] mode_q,
  output logic              stat_hit,
  output logic [DATA_W-1:0] stat_data
);
  logic rd, hit_bank, hit_src;

  assign rd       = acc_valid && !acc_we;
  assign hit_bank = rd && (acc_addr == STAT_BANK);
  assign hit_src  = rd && (acc_addr == STAT_SRC);

  always_comb begin
    stat_hit  = hit_bank || hit_src || (sw_hit && !acc_we);
    stat_data = '0;
    if (hit_bank)     stat_data[DATA_W-1] = !mode_q[MB_BANK];
    else if (hit_src) stat_data[DATA_W-1] = !mode_reads_rom(mode_q);
  end
endmodule

// File: rtl/lcbank_ctrl.sv
module lcbank_ctrl
  import lcbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              altzp,
  output logic              region_hit,
  output logic              rom_read,
  output logic              ram_we,
  output logic              ram_aux,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              stat_hit,
  output logic [DATA_W-1:0] stat_data
);
  logic              sw_hit;
  logic [MODE_W-1:0] mode_q;

  lcbank_state #(.ADDR_W(ADDR_W)) u_state (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .sw_hit(sw_hit), .mode_q(mode_q)
  );

  lcbank_map #(.ADDR_W(ADDR_W)) u_map (
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_addr(acc_addr), .altzp(altzp),
    .mode_q(mode_q), .region_hit(region_hit), .rom_read(rom_read),
    .ram_we(ram_we), .ram_aux(ram_aux), .ram_addr(ram_addr)
  );

  lcbank_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_status (
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_addr(acc_addr),
    .sw_hit(sw_hit), .mode_q(mode_q), .stat_hit(stat_hit), .stat_data(stat_data)
  );
endmodule

// File: rtl/lcbank_ctrl_chk.sv
module lcbank_ctrl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_we,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              altzp,
  input logic              region_hit,
  input logic              rom_read,
  input logic              ram_we,
  input logic              ram_aux,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              stat_hit,
  input logic [DATA_W-1:0] stat_data,
  input logic [3:0]        mode_q
);
  logic sw_acc;
  assign sw_acc = acc_valid && (acc_addr[ADDR_W-1:4] == 12'hC08);

  // R1
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_acc |=> (mode_q == ($past(acc_addr[3:0]) & 4'b1011)));
  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_acc |=> $stable(mode_q));
  // R12
  we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (acc_valid && acc_we && region_hit && mode_q[0]));
  // R6
  aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region_hit |-> (ram_aux == altzp));
  // R7
  outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !region_hit |-> (!rom_read && !ram_we && !ram_aux && ram_addr == acc_addr));
  // R5
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr[ADDR_W-1:ADDR_W-3] == 3'b111) |-> (ram_addr == acc_addr));
  // R4
  bank1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr[ADDR_W-1:ADDR_W-4] == 4'hD && mode_q[3]) |-> (ram_addr[ADDR_W-1:ADDR_W-4] == 4'hC));
  // R8
  stat_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_hit |-> (stat_data[DATA_W-2:0] == '0 && !acc_we));
endmodule

bind lcbank_ctrl lcbank_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
  .acc_addr(acc_addr), .altzp(altzp), .region_hit(region_hit),
  .rom_read(rom_read), .ram_we(ram_we), .ram_aux(ram_aux), .ram_addr(ram_addr),
  .stat_hit(stat_hit), .stat_data(stat_data), .mode_q(mode_q)
);

// File: tb/lcbank_ctrl_bench.sv
`timescale 1ns/1ps
module lcbank_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_we = 1'b0, altzp = 1'b0;
  logic [15:0] acc_addr = 16'h0000;
  logic region_hit, rom_read, ram_we, ram_aux, stat_hit;
  logic [15:0] ram_addr;
  logic [7:0] stat_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcbank_ctrl u_lcbank_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_addr(acc_addr), .altzp(altzp), .region_hit(region_hit),
    .rom_read(rom_read), .ram_we(ram_we), .ram_aux(ram_aux),
    .ram_addr(ram_addr), .stat_hit(stat_hit), .stat_data(stat_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s @%0t addr=%h: actual=%h expected=%h", req, $time, acc_addr, act, exp);
    end
  endtask

  task automatic acc(input logic [15:0] a, input logic we, input logic v);
    @(negedge clk);
    acc_valid = v; acc_we = we; acc_addr = a;
    #1;
  endtask

  initial begin
    logic [3:0] m;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R11: reset mode 0010
    acc(16'hC011, 0, 1); chk("R11 bank2 at reset", stat_data, 8'h80);
    acc(16'hC012, 0, 1); chk("R11 rom source at reset", stat_data, 8'h00);
    acc(16'hD000, 0, 1); chk("R11 rom_read", rom_read, 1);
    acc(16'hD000, 1, 1); chk("R11 write blocked", ram_we, 0);
    for (int i = 0; i < 16; i++) begin
      for (int w = 0; w < 2; w++) begin
        acc(16'hC080 + 16'(i), w[0], 1);
        // R10: read of the switch window returns 0
        if (w == 0) begin
          chk("R10 switch read hit", stat_hit, 1);
          chk("R10 switch read data", stat_data, 0);
        end
        m = 4'(i) & 4'b1011;
        for (int z = 0; z < 2; z++) begin
          altzp = z[0];
          acc(16'hD123, 0, 1);
          chk("R2 rom_read", rom_read, m[0] ^ m[1]);
          chk("R4 bank page addr", ram_addr, m[3] ? 16'hC123 : 16'hD123);
          chk("R6 aux select", ram_aux, z[0]);
          chk("R12 no strobe on read", ram_we, 0);
          acc(16'hD123, 1, 1);
          chk("R3 write enable", ram_we, m[0]);
          acc(16'hD123, 1, 0);
          chk("R12 no strobe when idle", ram_we, 0);
          acc(16'hE456, 0, 1);
          chk("R5 upper addr fixed", ram_addr, 16'hE456);
          chk("R2 upper rom_read", rom_read, m[0] ^ m[1]);
          acc(16'hFFFF, 1, 1);
          chk("R3 upper write enable", ram_we, m[0]);
          acc(16'hCFFF, 1, 1);
          chk("R7 outside region", {region_hit, rom_read, ram_we, ram_aux}, 0);
          chk("R7 outside addr", ram_addr, 16'hCFFF);
          acc(16'hC011, 0, 1);
          chk("R8 bank status", {stat_hit, stat_data}, {1'b1, !m[3], 7'b0});
          acc(16'hC012, 0, 1);
          chk("R9 source status", {stat_hit, stat_data}, {1'b1, m[0] == m[1], 7'b0});
        end
        altzp = 1'b0;
      end
    end
    // R1: a write to the status address does not change the mode
    acc(16'hC08B, 1, 1);
    acc(16'hC011, 1, 1);
    acc(16'hD000, 1, 1); chk("R1 mode kept after non-switch write", ram_we, 1);
    acc(16'hC011, 0, 1); chk("R1 mode kept bank1", stat_data, 8'h00);
    acc_valid = 1'b0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule